// File: doc/BRIEF.md
# Oscillator and PLL Enable Arbiter

This block decides on every clock edge whether the high-frequency oscillator and the PLL are enabled. It combines four sources into a single decision. The first is the current power mode. The second is a pair of explicit disable bits, one for the oscillator and one for the PLL. The third is a pair of hold bits, which act only while the radio link controller reports sleep. The fourth is a global PLL power-down bit.

The mode overrides the disable and hold bits in every mode except Power Save and Idle. An explicit disable bit takes precedence over its matching hold bit. The PLL power-down bit acts in all modes and never touches the oscillator.

Both enables are registered, so they change only on clock edges. A settle counter models the oscillator start-up time. It raises a stable flag a fixed number of edges after the oscillator enable rises. The PLL is only allowed on once that flag is high.

Top module: `osc_pll_enable_arbiter`

## Requirements
- R1: `mode_i` is encoded 0 = Active, 1 = Power Save, 2 = Idle, 3 = Halt. In Active mode `osc_en_o` is 1 on the edge after the mode is sampled, and `pll_en_o` is requested unless `pll_pwrdn_i` is set.
- R2: In Halt mode, both `osc_en_o` and `pll_en_o` are 0 from the next edge on.
- R3: In Power Save or Idle mode, `osc_off_i` = 1 turns the oscillator off.
- R4: In Power Save or Idle mode, `pll_off_i` = 1 turns the PLL off.
- R5: In Power Save or Idle mode, while `radio_sleep_i` = 1, `osc_hold_i` turns the oscillator off and `pll_hold_i` turns the PLL off. While `radio_sleep_i` = 0, the hold bits have no effect.
- R6: A set disable bit forces its source off whatever the matching hold bit and `radio_sleep_i` are.
- R7: `pll_pwrdn_i` = 1 forces `pll_en_o` to 0 in every mode and never changes `osc_en_o`.
- R8: In Active and Halt modes, the disable, hold and radio-sleep inputs have no effect on either output.
- R9: `osc_en_o` reflects the inputs sampled at the previous edge (one register of latency), and the outputs only change on clock edges.
- R10: `osc_stable_o` rises exactly SETTLE_CYCLES edges after the edge on which `osc_en_o` rises. It is 0 whenever `osc_en_o` is 0, and it falls on the same edge as `osc_en_o`.
- R11: `pll_en_o` is 1 only while `osc_stable_o` is 1. When the PLL is requested, `pll_en_o` rises on the edge after `osc_stable_o` rises.
- R12: While `rst_ni` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Power mode (0 Active, 1 Power Save, 2 Idle, 3 Halt) |
| osc_off_i | input | 1 | Explicit oscillator disable |
| pll_off_i | input | 1 | Explicit PLL disable |
| osc_hold_i | input | 1 | Oscillator off while radio sleeps |
| pll_hold_i | input | 1 | PLL off while radio sleeps |
| radio_sleep_i | input | 1 | Radio link controller is asleep |
| pll_pwrdn_i | input | 1 | Global PLL power-down |
| osc_en_o | output | 1 | Registered oscillator enable |
| pll_en_o | output | 1 | Registered PLL enable |
| osc_stable_o | output | 1 | Oscillator has settled since its last enable |

## Verification
The assertions take two things for granted:
- `mode_i` and the control bits are steady around each clock edge.
- Every value of `mode_i` is legal, because all four codes are defined.

The stimulus changes inputs only one time unit after a rising edge and holds them steady for several edges. It sweeps all four modes against all 64 combinations of the six control bits. Before each combination it parks the block in Halt mode, so each settle window starts from a known off state. This also exercises the same-edge fall of the stable flag.

// File: rtl/oscpll_pkg.sv
package oscpll_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_SAVE = 2'd1,
        PM_DOZE = 2'd2,
        PM_STOP = 2'd3
    } pm_mode_e;

    // Index of each clock source in the per-source arrays
    localparam int unsigned SRC_OSC = 0;
    localparam int unsigned SRC_PLL = 1;
    localparam int unsigned SRC_N   = 2;

    typedef struct packed {
        logic osc_en;
        logic pll_en;
    } en_state_t;

endpackage

// File: rtl/oscpll_policy.sv
module oscpll_policy
    import oscpll_pkg::*;
(
    input  pm_mode_e         mode_i,
    input  logic [SRC_N-1:0] off_i,
    input  logic [SRC_N-1:0] hold_i,
    input  logic             radio_sleep_i,
    input  logic             pll_pwrdn_i,
    output logic [SRC_N-1:0] req_o
);

    logic low_power;
    assign low_power = (mode_i == PM_SAVE) || (mode_i == PM_DOZE);

    logic [SRC_N-1:0] gated_off;

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        logic forced_off;
        logic mode_req;

        // Explicit disable first, then sleep-linked hold
        always_comb begin
            if (off_i[s]) begin
                gated_off[s] = 1'b1;
            end else begin
                gated_off[s] = hold_i[s] & radio_sleep_i;
            end
        end

        always_comb begin
            unique case (mode_i)
                PM_RUN:  mode_req = 1'b1;
                PM_STOP: mode_req = 1'b0;
                default: mode_req = ~gated_off[s];
            endcase
        end

        if (s == SRC_PLL) begin : g_pwrdn
            assign forced_off = pll_pwrdn_i;
        end else begin : g_nopwrdn
            assign forced_off = 1'b0;
        end

        assign req_o[s] = mode_req & ~forced_off;
    end

    // R6
    always_comb begin
        if (low_power) begin
            disable_wins_chk: assert (!(off_i[SRC_OSC] && req_o[SRC_OSC]));
        end
    end

endmodule

// File: rtl/oscpll_settle.sv
module oscpll_settle #(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_next_i,
    output logic stable_o
);

    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stable;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_next_i) begin
            st_d.cnt    = '0;
            st_d.stable = 1'b0;
        end else if (!st_q.stable) begin
            if (st_q.cnt == LIMIT) begin
                st_d.stable = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stable_o = st_q.stable;

    // R10
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LIMIT);

    // R10
    early_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.stable) |-> (st_q.cnt == LIMIT));

endmodule

// File: rtl/osc_pll_enable_arbiter.sv
module osc_pll_enable_arbiter
    import oscpll_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       osc_off_i,
    input  logic       pll_off_i,
    input  logic       osc_hold_i,
    input  logic       pll_hold_i,
    input  logic       radio_sleep_i,
    input  logic       pll_pwrdn_i,
    output logic       osc_en_o,
    output logic       pll_en_o,
    output logic       osc_stable_o
);

    pm_mode_e         mode;
    logic [SRC_N-1:0] off_vec;
    logic [SRC_N-1:0] hold_vec;
    logic [SRC_N-1:0] req;
    logic             stable;
    en_state_t        en_d, en_q;

    assign mode = pm_mode_e'(mode_i);

    always_comb begin
        off_vec           = '0;
        hold_vec          = '0;
        off_vec[SRC_OSC]  = osc_off_i;
        off_vec[SRC_PLL]  = pll_off_i;
        hold_vec[SRC_OSC] = osc_hold_i;
        hold_vec[SRC_PLL] = pll_hold_i;
    end

    oscpll_policy policy_i (
        .mode_i        (mode),
        .off_i         (off_vec),
        .hold_i        (hold_vec),
        .radio_sleep_i (radio_sleep_i),
        .pll_pwrdn_i   (pll_pwrdn_i),
        .req_o         (req)
    );

    always_comb begin
        en_d        = en_q;
        en_d.osc_en = req[SRC_OSC];
        // PLL waits for a settled oscillator and drops with it
        en_d.pll_en = req[SRC_PLL] & req[SRC_OSC] & stable;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    oscpll_settle #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) settle_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_next_i (en_d.osc_en),
        .stable_o  (stable)
    );

    assign osc_en_o     = en_q.osc_en;
    assign pll_en_o     = en_q.pll_en;
    assign osc_stable_o = stable;

    // R1
    run_osc_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0) |=> osc_en_o);

    // R2
    stop_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd3) |=> (!osc_en_o && !pll_en_o));

    // R7
    pwrdn_pll_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_pwrdn_i |=> !pll_en_o);

    // R11
    pll_needs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_en_o |-> osc_stable_o);

    // R10
    stable_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_stable_o |-> osc_en_o);

endmodule

// File: tb/osc_pll_enable_arbiter_tb.sv
module osc_pll_enable_arbiter_tb_top;

    localparam int unsigned SETTLE = 4;
    localparam int unsigned WATCHDOG = 100000;

    logic       clk;
    logic       rst_n;
    logic [1:0] mode;
    logic       osc_off, pll_off, osc_hold, pll_hold, sleep, pwrdn;
    logic       osc_en, pll_en, stable;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    osc_pll_enable_arbiter #(
        .SETTLE_CYCLES (SETTLE)
    ) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .mode_i        (mode),
        .osc_off_i     (osc_off),
        .pll_off_i     (pll_off),
        .osc_hold_i    (osc_hold),
        .pll_hold_i    (pll_hold),
        .radio_sleep_i (sleep),
        .pll_pwrdn_i   (pwrdn),
        .osc_en_o      (osc_en),
        .pll_en_o      (pll_en),
        .osc_stable_o  (stable)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0;
        mode = 2'd0;
        {osc_off, pll_off, osc_hold, pll_hold, sleep, pwrdn} = '0;
        step();
        step();
        // R12: reset holds all outputs low
        check("R12 osc_en", osc_en, 1'b0);
        check("R12 pll_en", pll_en, 1'b0);
        check("R12 stable", stable, 1'b0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 64; b++) begin
                logic eo, ep;
                string tag;
                // Park in Halt so the window starts from off
                mode = 2'd3;
                step();
                // R2 / R10: halt drops everything, stable falls with osc_en
                check("R2 park osc_en", osc_en, 1'b0);
                check("R2 park pll_en", pll_en, 1'b0);
                check("R10 park stable", stable, 1'b0);
                step();

                mode = 2'(m);
                {osc_off, pll_off, osc_hold, pll_hold, sleep, pwrdn} = 6'(b);
                case (m)
                    0: begin
                        eo = 1'b1; ep = ~pwrdn; tag = "R1 R7 R8 run";
                    end
                    3: begin
                        eo = 1'b0; ep = 1'b0; tag = "R2 R8 halt";
                    end
                    default: begin
                        eo = ~(osc_off | (sleep & osc_hold));
                        ep = ~pwrdn & ~(pll_off | (sleep & pll_hold));
                        tag = "R3 R4 R5 R6 R7 lowpower";
                    end
                endcase
                for (int k = 1; k <= int'(SETTLE) + 3; k++) begin
                    step();
                    // R9: one edge of latency on the oscillator enable
                    check({tag, " R9 osc_en"}, osc_en, eo);
                    // R10: stable after exactly SETTLE edges
                    check({tag, " R10 stable"}, stable,
                          eo && (k >= int'(SETTLE) + 1));
                    // R11: PLL one edge after stable
                    check({tag, " R11 pll_en"}, pll_en,
                          ep && eo && (k >= int'(SETTLE) + 2));
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule